// File: doc/BRIEF.md
# E1 Oversampling Clock and Data Recovery with Carrier-Loss Fallback

This block takes an E1 line that has already been reduced to two digital pulse indicators, one for positive marks and one for negative marks. Both indicators are sampled on a clock running at 32 times the bit rate. In the intended system that clock comes from both edges of a reference at four times the crystal frequency. In the RTL it is a single clock, `clk_i`. A 5-bit phase counter locks to the leading edge of each pulse. The block then slices one data bit per bit cell, with either polarity decoded as a logic 1. It also produces a recovered bit clock and flags a bipolar violation whenever two successive marks have the same polarity.

A carrier monitor declares receive carrier loss after a long run of empty bit cells. It lifts the condition again once marks return at sufficient density. While carrier is lost, the receive clock output is taken from a substitute source. The choice depends on two inputs: an activity detector on the alternate clock input, and a configuration bit that says whether the downstream jitter attenuator sits in the receive or the transmit path. A coded source selector tells the surrounding logic whether the chosen clock is meant to pass through the attenuator. The recovered clock is built from coarse phase steps, so its high phase may be shortened when the counter re-aligns. Downstream attenuation is expected to smooth this.

Top module: `e1_clk_recovery`

## Requirements
- R1: After reset, `rcl_o`, `rdata_o`, `bpv_o` and `alt_present_o` are 0, and `src_o` is 0 (recovered clock).
- R2: When a sample has a mark after a sample without one, the phase counter loads 8. Otherwise the counter increments modulo 32. The bit is sliced when the phase equals 16, which is the ninth sample after the edge sample. `rclk_o` in normal operation is high for phase 0 to 15, so it is low 20 samples after a mark edge and high 28 samples after it.
- R3: At each slice, `rdata_o` takes 1 if `pos_i` or `neg_i` is high and 0 if neither is high. It holds that value until the next slice.
- R4: At a slice with a mark, `bpv_o` becomes 1 when the polarity matches the previous mark, and is 0 otherwise. The first mark after reset is never flagged. `bpv_o` holds for one bit period, and a space slice clears it.
- R5: `rcl_o` rises at the slice of the 192nd consecutive space bit, and not before.
- R6: While `rcl_o` is 1, slices are grouped into 32-bit windows that start right after declaration. At the end of a window, `rcl_o` clears if that window held at least 12 marks; otherwise it stays set.
- R7: `alt_clk_i` is passed through a two-flop synchroniser and watched for rising edges. At the end of every 64-cycle window, `alt_present_o` is set to whether that window saw a rising edge. An input held low reads as absent.
- R8: `src_o` encodings:
  - 0: `rcl_o` is 0 (recovered clock).
  - 1: attenuator in receive path, alternate clock present (alternate clock via the attenuator).
  - 2: attenuator in receive path, alternate clock absent (free-running crystal clock).
  - 3: attenuator in transmit path, alternate clock present (alternate clock direct).
  - 4: attenuator in transmit path, alternate clock absent (transmit clock via the attenuator).
- R9: `rclk_o` follows the source that `src_o` names:
  - code 0: the recovered clock.
  - codes 1 and 3: `alt_clk_i`.
  - code 2: `xtal_clk_i`.
  - code 4: `tx_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 32x bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_i | input | 1 | Positive pulse indicator, one sample per clock |
| neg_i | input | 1 | Negative pulse indicator, one sample per clock |
| alt_clk_i | input | 1 | Alternate clock, asynchronous |
| xtal_clk_i | input | 1 | Free-running crystal-derived bit clock |
| tx_clk_i | input | 1 | Transmit bit clock |
| ja_rx_path_i | input | 1 | 1: attenuator in receive path, 0: transmit path |
| rclk_o | output | 1 | Receive clock |
| rdata_o | output | 1 | Recovered data bit |
| bpv_o | output | 1 | Bipolar violation flag |
| rcl_o | output | 1 | Receive carrier loss |
| alt_present_o | output | 1 | Alternate clock activity detected |
| src_o | output | 3 | Receive clock source code |

## Verification
On every cycle, the checker confirms several local rules:
- the phase counter loads its centring value after each leading pulse edge;
- the data bit changes only one cycle after a slice point;
- a violation is never flagged on a space;
- carrier loss never rises on a slice that carried a mark;
- the presence flag moves only at a 64-cycle window boundary.

The exact counts need the bench's scenarios. These are the 192nd-space declaration, the 11-mark versus 12-mark recovery windows, and the whole source table under both attenuator placements. The same applies to the data, violation and clock-phase values over a stream with inserted violations.

// File: rtl/e1cr_pkg.sv
package e1cr_pkg;
  typedef enum logic [2:0] {
    SRC_RECOV      = 3'd0,
    SRC_ALT_JA     = 3'd1,
    SRC_XTAL       = 3'd2,
    SRC_ALT_DIRECT = 3'd3,
    SRC_TX_JA      = 3'd4
  } rclk_src_e;
endpackage

// File: rtl/e1cr_phase.sv
module e1cr_phase #(
  parameter int OSR = 32,
  localparam int PW = $clog2(OSR)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  output logic rec_clk_o,
  output logic sample_o,
  output logic mark_o,
  output logic data_o,
  output logic bpv_o
);
  localparam logic [PW-1:0] EDGE_LOAD = PW'(OSR / 4);
  localparam logic [PW-1:0] SLICE_PT  = PW'(OSR / 2);

  logic [PW-1:0] phase_q;
  logic mark_d_q, data_q, bpv_q, last_pos_q, seen_q;
  logic edge_det;

  assign mark_o   = pos_i | neg_i;
  assign edge_det = mark_o & ~mark_d_q;
  assign sample_o = (phase_q == SLICE_PT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= '0;
      mark_d_q   <= 1'b0;
      data_q     <= 1'b0;
      bpv_q      <= 1'b0;
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      mark_d_q <= mark_o;
      phase_q  <= edge_det ? EDGE_LOAD : phase_q + 1'b1;
      if (sample_o) begin
        data_q <= mark_o;
        bpv_q  <= mark_o & seen_q & (pos_i == last_pos_q);
        if (mark_o) begin
          last_pos_q <= pos_i;
          seen_q     <= 1'b1;
        end
      end
    end
  end

  // high half of the cell; a re-align may shorten it
  assign rec_clk_o = ~phase_q[PW-1];
  assign data_o    = data_q;
  assign bpv_o     = bpv_q;
endmodule

// File: rtl/e1cr_los.sv
module e1cr_los #(
  parameter int LOS_BITS  = 192,
  parameter int WIN_BITS  = 32,
  parameter int MIN_MARKS = 12,
  localparam int ZW = $clog2(LOS_BITS + 1),
  localparam int WW = $clog2(WIN_BITS),
  localparam int MW = $clog2(WIN_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic mark_i,
  output logic rcl_o
);
  logic [ZW-1:0] zrun_q;
  logic [WW-1:0] win_q;
  logic [MW-1:0] mk_q, mk_nxt;
  logic rcl_q;

  assign mk_nxt = mk_q + {{(MW-1){1'b0}}, mark_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zrun_q <= '0;
      win_q  <= '0;
      mk_q   <= '0;
      rcl_q  <= 1'b0;
    end else if (sample_i) begin
      if (mark_i)                          zrun_q <= '0;
      else if (zrun_q < ZW'(LOS_BITS - 1)) zrun_q <= zrun_q + 1'b1;
      if (!rcl_q) begin
        if (!mark_i && zrun_q == ZW'(LOS_BITS - 1)) begin
          rcl_q <= 1'b1;
          win_q <= '0;
          mk_q  <= '0;
        end
      end else begin
        win_q <= win_q + 1'b1;
        if (win_q == WW'(WIN_BITS - 1)) begin
          mk_q <= '0;
          if (mk_nxt >= MW'(MIN_MARKS)) rcl_q <= 1'b0;
        end else begin
          mk_q <= mk_nxt;
        end
      end
    end
  end

  assign rcl_o = rcl_q;
endmodule

// File: rtl/e1cr_act_det.sv
module e1cr_act_det #(
  parameter int WIN = 64,
  localparam int WW = $clog2(WIN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic present_o
);
  logic [2:0] sync_q;
  logic [WW-1:0] win_q;
  logic seen_q, present_q, rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '0;
      win_q     <= '0;
      seen_q    <= 1'b0;
      present_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], async_i};
      win_q  <= win_q + 1'b1;
      if (win_q == WW'(WIN - 1)) begin
        present_q <= seen_q | rise;
        seen_q    <= 1'b0;
      end else begin
        seen_q <= seen_q | rise;
      end
    end
  end

  assign present_o = present_q;
endmodule

// File: rtl/e1_clk_recovery.sv
module e1_clk_recovery
  import e1cr_pkg::*;
#(
  parameter int OSR       = 32,
  parameter int LOS_BITS  = 192,
  parameter int WIN_BITS  = 32,
  parameter int MIN_MARKS = 12,
  parameter int ACT_WIN   = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pos_i,
  input  logic       neg_i,
  input  logic       alt_clk_i,
  input  logic       xtal_clk_i,
  input  logic       tx_clk_i,
  input  logic       ja_rx_path_i,
  output logic       rclk_o,
  output logic       rdata_o,
  output logic       bpv_o,
  output logic       rcl_o,
  output logic       alt_present_o,
  output logic [2:0] src_o
);
  logic rec_clk, sample, mark;
  rclk_src_e src;

  e1cr_phase #(.OSR(OSR)) u_phase (
    .clk_i, .rst_ni, .pos_i, .neg_i,
    .rec_clk_o(rec_clk), .sample_o(sample), .mark_o(mark),
    .data_o(rdata_o), .bpv_o(bpv_o)
  );

  e1cr_los #(.LOS_BITS(LOS_BITS), .WIN_BITS(WIN_BITS), .MIN_MARKS(MIN_MARKS)) u_los (
    .clk_i, .rst_ni, .sample_i(sample), .mark_i(mark), .rcl_o(rcl_o)
  );

  e1cr_act_det #(.WIN(ACT_WIN)) u_act (
    .clk_i, .rst_ni, .async_i(alt_clk_i), .present_o(alt_present_o)
  );

  always_comb begin
    if (!rcl_o)            src = SRC_RECOV;
    else if (ja_rx_path_i) src = alt_present_o ? SRC_ALT_JA : SRC_XTAL;
    else                   src = alt_present_o ? SRC_ALT_DIRECT : SRC_TX_JA;
  end

  always_comb begin
    unique case (src)
      SRC_ALT_JA, SRC_ALT_DIRECT: rclk_o = alt_clk_i;
      SRC_XTAL:                   rclk_o = xtal_clk_i;
      SRC_TX_JA:                  rclk_o = tx_clk_i;
      default:                    rclk_o = rec_clk;
    endcase
  end

  assign src_o = src;
endmodule

// File: rtl/e1_clk_recovery_chk.sv
module e1_clk_recovery_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pos_i,
  input logic       neg_i,
  input logic       rdata_o,
  input logic       bpv_o,
  input logic       rcl_o,
  input logic       alt_present_o,
  input logic [4:0] phase_i,
  input logic [5:0] act_win_i
);
  logic mark;
  assign mark = pos_i | neg_i;

  // R2: leading pulse edge centres the phase counter
  assert_edge_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark && !$past(mark)) |=> (phase_i == 5'd8));

  // R3: data moves only right after a slice point
  assert_data_on_slice_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> ($past(phase_i) == 5'd16));

  // R4: a violation is always a mark
  assert_bpv_on_mark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpv_o |-> rdata_o);

  // R5: loss is declared on a space slice
  assert_rcl_on_space_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rcl_o) |-> !rdata_o);

  // R7: presence changes only at a window boundary
  assert_present_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(alt_present_o) |-> ($past(act_win_i) == 6'd63));
endmodule

bind e1_clk_recovery e1_clk_recovery_chk u_chk (
  .clk_i, .rst_ni, .pos_i, .neg_i, .rdata_o, .bpv_o, .rcl_o, .alt_present_o,
  .phase_i(u_phase.phase_q), .act_win_i(u_act.win_q)
);

// File: tb/e1_clk_recovery_tb.sv
module e1_clk_recovery_tb;
  logic clk = 0, rst_n = 0, pos = 0, neg = 0;
  logic alt_clk = 0, alt_en = 0, xtal = 0, txc = 0, ja_rx = 1;
  logic rclk, rdata, bpv, rcl, alt_pr;
  logic [2:0] src;

  e1_clk_recovery u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pos_i(pos), .neg_i(neg),
    .alt_clk_i(alt_clk), .xtal_clk_i(xtal), .tx_clk_i(txc), .ja_rx_path_i(ja_rx),
    .rclk_o(rclk), .rdata_o(rdata), .bpv_o(bpv), .rcl_o(rcl),
    .alt_present_o(alt_pr), .src_o(src)
  );

  always #5  clk = ~clk;
  always #40 xtal = ~xtal;
  always #70 txc = ~txc;
  always #30 alt_clk = alt_en ? ~alt_clk : 1'b0;

  int n_chk = 0, n_bad = 0, since_rcl = 0;
  logic cap_d, cap_b, cap_rcl, cap_k20, cap_k28, next_pos = 1;

  // {pos, neg, exp_data, exp_bpv}
  localparam logic [3:0] VEC [12] = '{
    4'b1010, 4'b0000, 4'b0110, 4'b1010, 4'b1011, 4'b0000,
    4'b0110, 4'b0111, 4'b0000, 4'b0000, 4'b1010, 4'b0110
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic send_bit(input logic p, input logic n);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      if (c == 20) begin cap_d = rdata; cap_b = bpv; cap_rcl = rcl; cap_k20 = rclk; end
      if (c == 28) cap_k28 = rclk;
      pos = p && (c < 16);
      neg = n && (c < 16);
    end
    since_rcl++;
  endtask

  task automatic send_mark();
    send_bit(next_pos, !next_pos);
    next_pos = !next_pos;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 got 0 exp 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rcl", rcl, 0);
    chk("R1 data", rdata, 0);
    chk("R1 bpv", bpv, 0);
    chk("R1 present", alt_pr, 0);
    chk("R1 src", src, 0);
    rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      send_bit(VEC[i][3], VEC[i][2]);
      chk("R3 data", cap_d, VEC[i][1]);
      chk("R4 bpv", cap_b, VEC[i][0]);
      chk("R2 rclk low at 20", cap_k20, 0);
      chk("R2 rclk high at 28", cap_k28, 1);
    end
    next_pos = 1;

    for (int i = 0; i < 191; i++) send_bit(0, 0);
    chk("R5 no loss at 191", cap_rcl, 0);
    send_bit(0, 0);
    chk("R5 loss at 192", cap_rcl, 1);
    since_rcl = 0;

    @(negedge clk);
    chk("R8 xtal", src, 2);
    chk("R9 xtal", rclk, xtal);
    ja_rx = 0;
    @(negedge clk);
    chk("R8 tx", src, 4);
    chk("R9 tx", rclk, txc);

    alt_en = 1;
    for (int i = 0; i < 8; i++) send_bit(0, 0);
    chk("R7 present", alt_pr, 1);
    chk("R8 alt direct", src, 3);
    chk("R9 alt direct", rclk, alt_clk);
    ja_rx = 1;
    @(negedge clk);
    chk("R8 alt via ja", src, 1);
    chk("R9 alt via ja", rclk, alt_clk);

    alt_en = 0;
    for (int i = 0; i < 8; i++) send_bit(0, 0);
    chk("R7 tied low absent", alt_pr, 0);
    chk("R8 xtal again", src, 2);

    while (since_rcl % 32 != 0) send_bit(0, 0);
    for (int i = 0; i < 32; i++) begin
      if (i < 11) send_mark(); else send_bit(0, 0);
    end
    chk("R6 11 marks keep loss", cap_rcl, 1);
    for (int i = 0; i < 31; i++) begin
      if (i < 12) send_mark(); else send_bit(0, 0);
    end
    chk("R6 before window end", cap_rcl, 1);
    send_bit(0, 0);
    chk("R6 12 marks clear", cap_rcl, 0);
    @(negedge clk);
    chk("R8 recovered", src, 0);

    summary();
    $finish;
  end
endmodule